// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of each beat of one double-data-rate DRAM burst. A start strobe hands it a starting column, a length code and an ordering type. From the next cycle on it presents one column per clock with a valid flag, and it raises a last flag on the final beat. Only the low column bits that the burst length selects follow the ordering. Every other column bit keeps the value given at the start.

Two orderings are available. Sequential ordering counts the active low field up by one on each beat and wraps inside the aligned block. Interleaved ordering XORs the starting field with the beat index. The length and type are captured with the start and held for the whole burst. A start presented on the last beat chains the next burst with no idle cycle. A start presented earlier in a burst is dropped and flagged.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous active-low reset, valid_o, last_o and busy_err_o are 0.
- R2: A start seen while idle is accepted at that clock edge. The first beat appears on the next cycle with valid_o=1 and col_o equal to start_col_i. Further beats follow one per cycle.
- R3: blen_i code 1 selects 2 beats with ordering field bit 0. Code 2 selects 4 beats with field bits 1:0. Code 3 selects 8 beats with field bits 2:0. Code 0 behaves exactly like code 1.
- R4: When btype_i=0 (sequential), each beat's active field is the previous one plus 1, modulo the burst length. Start 5 with 8 beats gives 5,6,7,0,1,2,3,4. Start 3 with 4 beats gives 3,0,1,2.
- R5: When btype_i=1 (interleaved), the active field of beat n is the starting field XOR n. Start 5 with 8 beats gives 5,4,7,6,1,0,3,2. Start 1 with 4 beats gives 1,0,3,2.
- R6: With 2 beats both types give the same order: 0,1 from an even start and 1,0 from an odd start.
- R7: Every column bit outside the active field equals the matching bit of start_col_i on every beat. This includes low bits above a short field.
- R8: Length, type and starting column are captured on an accepted start. Changes on start_col_i, blen_i or btype_i during the burst do not affect it.
- R9: last_o is 1 on the final beat only. If no start is presented on that cycle, valid_o is 0 on the next cycle.
- R10: A start presented on the final-beat cycle is accepted. Its first beat follows on the next cycle without a gap, and busy_err_o stays 0.
- R11: A start presented during a burst other than on its final beat is ignored, and the running burst continues unchanged. busy_err_o is 1 for exactly the one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe for a burst |
| start_col_i | input | COL_W | Starting column address |
| blen_i | input | 2 | Length code: 1→2, 2→4, 3→8 beats, 0 same as 1 |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one |
| busy_err_o | output | 1 | One-cycle pulse after a dropped start |

## Verification
The vector table covers starting offsets that sit at the top of their block, where sequential order must wrap. A design that forgot the wrap would carry into the upper column bits and break R7. Some length-4 and length-2 cases start from a column whose bit 2 is set, so a design that masked with the widest field would disturb that bit. The directed tests chain a burst from the last beat, drop a start in mid-burst, change the configuration inputs during a burst, and use the reserved length code 0. A wrong design would add an idle cycle, restart or stretch the burst, or run for the wrong number of beats.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst column sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package burst_seq_pkg;
    typedef enum logic {
        ORDER_SEQ = 1'b0,
        ORDER_ILV = 1'b1
    } order_e;
endpackage

// File: rtl/bcs_ctrl.sv
// Burst control: accepts starts, captures configuration, counts beats,
// flags the final beat and reports starts that arrive while busy.
// Assumes: length code 0 is treated as the shortest burst; codes above
// MAX_LOG2 are clamped to the longest burst.
module bcs_ctrl
    import burst_seq_pkg::*;
#(
    parameter int COL_W    = 10,
    parameter int MAX_LOG2 = 3,
    localparam int OFS_W   = MAX_LOG2,
    localparam int LEN_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LEN_W-1:0] len_code_i,
    input  order_e           order_i,
    output logic             active_o,
    output logic             last_o,
    output logic [OFS_W-1:0] beat_o,
    output logic [OFS_W-1:0] mask_o,
    output logic [COL_W-1:0] base_o,
    output order_e           order_o,
    output logic             err_o
);
    logic             active_q;
    logic [OFS_W-1:0] beat_q;
    logic [OFS_W-1:0] mask_q;
    logic [COL_W-1:0] base_q;
    order_e           order_q;
    logic             err_q;
    logic [OFS_W-1:0] mask_in;
    logic [LEN_W-1:0] k_eff;
    logic             last;
    logic             accept;

    // Turn the length code into a field mask with k_eff low ones.
    always_comb begin
        if (len_code_i == '0)
            k_eff = LEN_W'(1);
        else if (int'(len_code_i) > MAX_LOG2)
            k_eff = LEN_W'(MAX_LOG2);
        else
            k_eff = len_code_i;
        for (int i = 0; i < OFS_W; i++)
            mask_in[i] = (i < int'(k_eff));
    end

    // The final beat is the one whose index equals length minus one.
    assign last   = active_q && (beat_q == mask_q);
    assign accept = start_i && (!active_q || last);

    // Burst state: load on accept, advance per beat, drop to idle after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            beat_q   <= '0;
            mask_q   <= '0;
            base_q   <= '0;
            order_q  <= ORDER_SEQ;
            err_q    <= 1'b0;
        end else begin
            err_q <= start_i && active_q && !last;
            if (accept) begin
                active_q <= 1'b1;
                beat_q   <= '0;
                mask_q   <= mask_in;
                base_q   <= start_col_i;
                order_q  <= order_i;
            end else if (active_q) begin
                if (last)
                    active_q <= 1'b0;
                else
                    beat_q <= beat_q + OFS_W'(1);
            end
        end
    end

    assign active_o = active_q;
    assign last_o   = last;
    assign beat_o   = beat_q;
    assign mask_o   = mask_q;
    assign base_o   = base_q;
    assign order_o  = order_q;
    assign err_o    = err_q;

    // R3: the beat index never leaves the selected field
    assert_beat_in_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> ((beat_q & ~mask_q) == '0));

    // R8: configuration is held while the burst runs
    assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !last) |=> ($stable(mask_q) && $stable(order_q) && $stable(base_q)));

    // R11: a start in mid-burst neither restarts nor stops it, and is flagged
    assert_busy_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && active_q && !last) |=>
            (active_q && err_o && (beat_q == OFS_W'($past(beat_q) + OFS_W'(1)))));

    // R9: with no start on the last beat the block goes idle
    assert_idle_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start_i) |=> !active_q);

    // R10: a start on the last beat chains straight into beat zero
    assert_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (last && start_i) |=> (active_q && beat_q == '0 && !err_o));
endmodule

// File: rtl/bcs_order.sv
// Ordering arithmetic: forms the beat column from the captured start,
// the field mask and the beat index.
// Assumes: beat index stays inside the mask, so XOR needs no extra masking.
module bcs_order
    import burst_seq_pkg::*;
#(
    parameter int COL_W    = 10,
    parameter int MAX_LOG2 = 3,
    localparam int OFS_W   = MAX_LOG2
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [OFS_W-1:0] mask_i,
    input  logic [OFS_W-1:0] beat_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] col_o
);
    logic [OFS_W-1:0] low;
    logic [OFS_W-1:0] calc;
    logic [OFS_W-1:0] merged;

    assign low = base_i[OFS_W-1:0];

    // Pick wrap-by-addition or XOR ordering for the low field.
    always_comb begin
        if (order_i == ORDER_ILV)
            calc = low ^ beat_i;
        else
            calc = low + beat_i;
    end

    // Per bit: inside the field take the ordered value, outside keep the start.
    for (genvar i = 0; i < OFS_W; i++) begin : g_merge
        assign merged[i] = mask_i[i] ? calc[i] : low[i];
    end

    // Upper column bits pass through untouched.
    if (COL_W > OFS_W) begin : g_upper
        assign col_o = {base_i[COL_W-1:OFS_W], merged};
    end else begin : g_noupper
        assign col_o = merged;
    end
endmodule

// File: rtl/burst_col_seq.sv
// Top of the burst column sequencer: control plus ordering arithmetic.
// Assumes: one beat per clock; outputs are driven from captured state
// through the ordering logic.
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W    = 10,
    parameter int MAX_LOG2 = 3,
    localparam int OFS_W   = MAX_LOG2,
    localparam int LEN_W   = $clog2(MAX_LOG2 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LEN_W-1:0] blen_i,
    input  logic             btype_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             busy_err_o
);
    logic [OFS_W-1:0] beat;
    logic [OFS_W-1:0] mask;
    logic [COL_W-1:0] base;
    order_e           ord;

    bcs_ctrl #(.COL_W(COL_W), .MAX_LOG2(MAX_LOG2)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .start_col_i(start_col_i),
        .len_code_i (blen_i),
        .order_i    (order_e'(btype_i)),
        .active_o   (valid_o),
        .last_o     (last_o),
        .beat_o     (beat),
        .mask_o     (mask),
        .base_o     (base),
        .order_o    (ord),
        .err_o      (busy_err_o)
    );

    bcs_order #(.COL_W(COL_W), .MAX_LOG2(MAX_LOG2)) u_order (
        .base_i (base),
        .mask_i (mask),
        .beat_i (beat),
        .order_i(ord),
        .col_o  (col_o)
    );

    // R7: bits outside the active field do not move between beats
    assert_outside_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=>
            (((col_o[OFS_W-1:0] ^ $past(col_o[OFS_W-1:0])) & ~mask) == '0));

    // R4: sequential field steps by one modulo the length
    assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && ord == ORDER_SEQ) |=>
            (((col_o[OFS_W-1:0] - $past(col_o[OFS_W-1:0])) & mask) == OFS_W'(1)));

    // R5: interleaved field changes by exactly the change of beat index
    assert_ilv_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && ord == ORDER_ILV) |=>
            (((col_o[OFS_W-1:0] ^ $past(col_o[OFS_W-1:0])) & mask) == (beat ^ $past(beat))));
endmodule

// File: tb/test_burst_col_seq.sv
// Self-checking bench: vector table of bursts, then directed corner tests.
module test_burst_col_seq;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 10;
    localparam int NVEC  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [1:0]       blen_i = '0;
    logic             btype_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, busy_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W), .MAX_LOG2(3)) i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .btype_i(btype_i), .col_o(col_o), .valid_o(valid_o),
        .last_o(last_o), .busy_err_o(busy_err_o)
    );

    // Vector: {start col[10], length code[2], type[1], 8 expected low fields of 3 bits}
    localparam logic [36:0] VEC [NVEC] = '{
        {10'h3C5, 2'd3, 1'b0, 3'd5, 3'd6, 3'd7, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4},
        {10'h3C5, 2'd3, 1'b1, 3'd5, 3'd4, 3'd7, 3'd6, 3'd1, 3'd0, 3'd3, 3'd2},
        {10'h001, 2'd2, 1'b0, 3'd1, 3'd2, 3'd3, 3'd0, 12'd0},
        {10'h001, 2'd2, 1'b1, 3'd1, 3'd0, 3'd3, 3'd2, 12'd0},
        {10'h103, 2'd2, 1'b0, 3'd3, 3'd0, 3'd1, 3'd2, 12'd0},
        {10'h103, 2'd2, 1'b1, 3'd3, 3'd2, 3'd1, 3'd0, 12'd0},
        {10'h0AE, 2'd2, 1'b0, 3'd6, 3'd7, 3'd4, 3'd5, 12'd0},
        {10'h0AE, 2'd2, 1'b1, 3'd6, 3'd7, 3'd4, 3'd5, 12'd0},
        {10'h2F0, 2'd1, 1'b0, 3'd0, 3'd1, 18'd0},
        {10'h2F0, 2'd1, 1'b1, 3'd0, 3'd1, 18'd0},
        {10'h2F7, 2'd1, 1'b0, 3'd7, 3'd6, 18'd0},
        {10'h2F7, 2'd1, 1'b1, 3'd7, 3'd6, 18'd0},
        {10'h15B, 2'd0, 1'b0, 3'd3, 3'd2, 18'd0},
        {10'h000, 2'd3, 1'b1, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7},
        {10'h3FF, 2'd3, 1'b1, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
        {10'h083, 2'd3, 1'b0, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd0, 3'd1, 3'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [1:0] code);
        return (code == 2'd0) ? 2 : (1 << code);
    endfunction

    // Start a burst at a negedge; return at the negedge where beat 0 is visible.
    task automatic kick(input logic [9:0] col, input logic [1:0] len, input logic typ);
        start_col_i = col; blen_i = len; btype_i = typ; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid after reset", 32'(valid_o), 0);
        chk("R1 last after reset", 32'(last_o), 0);
        chk("R1 err after reset", 32'(busy_err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stays idle", 32'(valid_o), 0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [9:0] sc;
            logic [1:0] ln;
            logic       ty;
            int         nb;
            string      mtag;
            sc = VEC[v][36:27];
            ln = VEC[v][26:25];
            ty = VEC[v][24];
            nb = beats_of(ln);
            mtag = (nb == 2) ? ((ln == 2'd0) ? "R3/R6" : "R6") : (ty ? "R5" : "R4");
            kick(sc, ln, ty);
            for (int b = 0; b < nb; b++) begin
                logic [2:0] el;
                el = VEC[v][23 - 3*b -: 3];
                chk((b == 0) ? "R2 first beat" : mtag, 32'(col_o), 32'({sc[9:3], el}));
                chk("R7 upper bits", 32'(col_o[9:3]), 32'(sc[9:3]));
                chk("R2 valid", 32'(valid_o), 1);
                chk("R9 last flag", 32'(last_o), (b == nb - 1) ? 1 : 0);
                @(negedge clk);
            end
            chk("R9 idle after last", 32'(valid_o), 0);
            chk("R3 beat count", 32'(busy_err_o), 0);
        end

        // R8: inputs change mid-burst; burst keeps start 0x083, length 8, sequential
        kick(10'h083, 2'd3, 1'b0);
        start_col_i = 10'h3FF; blen_i = 2'd1; btype_i = 1'b1;
        for (int b = 0; b < 8; b++) begin
            chk("R8 captured config", 32'(col_o), 32'({7'h10, 3'(3 + b)}));
            chk("R8 last flag", 32'(last_o), (b == 7) ? 1 : 0);
            @(negedge clk);
        end
        chk("R8 idle after 8 beats", 32'(valid_o), 0);

        // R11: start on beat 2 of an 8-beat burst is dropped and flagged
        kick(10'h010, 2'd3, 1'b0);
        for (int b = 0; b < 8; b++) begin
            chk("R11 burst unchanged", 32'(col_o), 32'(10'h010 + b));
            chk("R11 err pulse", 32'(busy_err_o), (b == 3) ? 1 : 0);
            if (b == 2) begin
                start_col_i = 10'h2A0; blen_i = 2'd1; start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        chk("R11 ends at original length", 32'(valid_o), 0);

        // R10: chain a 4-beat interleaved burst off the last beat of a 2-beat one
        kick(10'h041, 2'd1, 1'b0);
        chk("R10 first burst beat0", 32'(col_o), 32'h041);
        @(negedge clk);
        chk("R10 first burst beat1", 32'(col_o), 32'h040);
        chk("R10 last before chain", 32'(last_o), 1);
        start_col_i = 10'h106; blen_i = 2'd2; btype_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 no gap", 32'(valid_o), 1);
        chk("R10 no error", 32'(busy_err_o), 0);
        chk("R10 chained beat0", 32'(col_o), 32'h106);
        @(negedge clk);
        chk("R10 chained beat1", 32'(col_o), 32'h107);
        @(negedge clk);
        chk("R10 chained beat2", 32'(col_o), 32'h104);
        @(negedge clk);
        chk("R10 chained beat3", 32'(col_o), 32'h105);
        chk("R10 chained last", 32'(last_o), 1);
        @(negedge clk);
        chk("R10 idle after chain", 32'(valid_o), 0);

        // R1: reset in mid-burst returns to idle
        kick(10'h000, 2'd3, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-burst", 32'(valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule